// File: doc/BRIEF.md
# Programmable Interval Timer with Prescaler

This block is a timer peripheral that sits on a simple synchronous register port. Software programs a reload value, a prescaler divisor and a control word. A down-counter then steps either on divided system clocks or on rising edges seen at an external event pin. When a step finds the counter already at zero, the timer expires. On expiry it raises a sticky interrupt flag, and it either emits a one-clock pulse on its output pin or inverts that pin to build a square wave.

In auto-reload mode the counter reloads on each expiry and keeps running, so interrupts arrive periodically. In one-shot mode the counter parks at zero and the run bit clears itself. The same external pin can instead serve as a level gate. While gating is enabled and the pin is low, prescaled steps are suppressed.

Top module: `ival_timer`

## Requirements
- R1: After reset, all four registers read zero and both the timer output pin and the interrupt line are low.
- R2: Register offsets are 0 for control, 1 for reload, 2 for prescaler and 3 for the current count. The prescaler keeps only its low PW bits. A write to offset 3 leaves the count unchanged. Control bits are: bit0 run, bit1 auto-reload, bit2 toggle output mode, bit3 gate enable, bit4 external event mode, and bit5 the interrupt flag.
- R3: A control write that sets run while run is clear loads the count from the reload register.
- R4: With prescaler value P, an internal count step happens once every P+1 system clocks. With reload R, the first expiry therefore comes (R+1)*(P+1) clocks after the starting write.
- R5: Expiry sets the interrupt flag, and the flag stays set until a control write with bit5 = 1. If an expiry and such a clearing write fall in the same cycle, the flag stays set.
- R6: With auto-reload set, expiry reloads the count from the reload register and the run bit stays set.
- R7: With auto-reload clear, expiry leaves the count at zero and clears the run bit.
- R8: In pulse mode (bit2 = 0), the output pin is high for exactly one clock after each isolated expiry.
- R9: In toggle mode (bit2 = 1), the output pin inverts on each expiry and holds its level in between.
- R10: With gate enabled and external mode off, the count holds while the synchronized pin is low. Counting starts three clocks after the pin rises.
- R11: In external mode the counter takes one step for each rising edge of the pin, after a two-flop synchronizer, and the prescaler has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data for bus_addr, combinational |
| ev_pin | input | 1 | External gate or event pin, asynchronous |
| tmr_pin | output | 1 | Timer output, pulse or square wave |
| irq | output | 1 | Sticky expiry interrupt |

## Verification
The bench builds the timer with an 8-bit count and a 4-bit prescaler. With those widths the largest divisor of 16 and the reload-zero case, where every step expires, both fall within short runs. Expiry intervals are measured as clock counts for several reload and divisor pairs. The tests also cover the clash between an expiry and a clearing write, the three-clock latency through the pin synchronizer in gate and event modes, and the toggle phase across two consecutive periods.

// File: rtl/ival_timer_pkg.sv
package ival_timer_pkg;

  localparam logic [1:0] OFF_CTRL   = 2'd0;
  localparam logic [1:0] OFF_RELOAD = 2'd1;
  localparam logic [1:0] OFF_PSC    = 2'd2;
  localparam logic [1:0] OFF_COUNT  = 2'd3;

  localparam int CTRL_BITS = 5;
  localparam int IRQ_BIT   = 5;

  // Field order sets bit positions: run is bit 0, ext is bit 4.
  typedef struct packed {
    logic ext;
    logic gate;
    logic tgl;
    logic autorl;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/ival_timer_sync.sv
module ival_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o
);

  logic [STAGES-1:0] sh_q, sh_d;
  logic              last_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/ival_timer_prescale.sv
module ival_timer_prescale #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          active,
  input  logic [PW-1:0] div,
  output logic          tick
);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pcnt_en;

  // >= keeps the period bounded when div is lowered mid-run
  assign tick = active & (pcnt_q >= div);

  always_comb begin
    pcnt_en = restart | active;
    if (restart || tick) pcnt_d = '0;
    else                 pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

endmodule

// File: rtl/ival_timer_regs.sv
module ival_timer_regs
  import ival_timer_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          reload_wr,
  input  logic          psc_wr,
  input  logic [CW-1:0] wdata,
  input  logic          expire,
  output ctrl_t         ctrl_o,
  output logic          irq_o,
  output logic [CW-1:0] reload_o,
  output logic [PW-1:0] psc_o,
  output logic          start_o
);

  ctrl_t         ctrl_q, ctrl_d;
  logic          irq_q, irq_d;
  logic [CW-1:0] reload_q;
  logic [PW-1:0] psc_q;
  logic          ctrl_en, irq_en;

  always_comb begin
    ctrl_d = ctrl_q;
    if (expire && !ctrl_q.autorl) ctrl_d.run = 1'b0;
    if (ctrl_wr) ctrl_d = ctrl_t'(wdata[CTRL_BITS-1:0]);
    ctrl_en = ctrl_wr | expire;
  end

  // Clearing write first, expiry last: a set in the same cycle wins.
  always_comb begin
    irq_d = irq_q;
    if (ctrl_wr && wdata[IRQ_BIT]) irq_d = 1'b0;
    if (expire)                    irq_d = 1'b1;
    irq_en = ctrl_wr | expire;
  end

  assign start_o = ctrl_wr & wdata[0] & ~ctrl_q.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      irq_q    <= 1'b0;
      reload_q <= '0;
      psc_q    <= '0;
    end else begin
      if (ctrl_en)   ctrl_q   <= ctrl_d;
      if (irq_en)    irq_q    <= irq_d;
      if (reload_wr) reload_q <= wdata;
      if (psc_wr)    psc_q    <= wdata[PW-1:0];
    end
  end

  assign ctrl_o   = ctrl_q;
  assign irq_o    = irq_q;
  assign reload_o = reload_q;
  assign psc_o    = psc_q;

endmodule

// File: rtl/ival_timer_count.sv
module ival_timer_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          evt,
  input  logic          run,
  input  logic          autorl,
  input  logic          tgl,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] cnt_o,
  output logic          expire_o,
  output logic          out_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          out_q, out_d, out_en;
  logic          at_zero, step;

  assign at_zero  = (cnt_q == '0);
  assign step     = evt & run;
  assign expire_o = step & at_zero;

  always_comb begin
    cnt_en = start | step;
    if (start)        cnt_d = reload;
    else if (at_zero) cnt_d = autorl ? reload : '0;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    out_en = ~tgl | expire_o;
    out_d  = tgl ? ~out_q : expire_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (out_en) out_q <= out_d;
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;

endmodule

// File: rtl/ival_timer.sv
module ival_timer
  import ival_timer_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          ev_pin,
  output logic          tmr_pin,
  output logic          irq
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rs_q;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rs_q[RST_STAGES-1];

  logic          wr_any, ctrl_wr, reload_wr, psc_wr;
  ctrl_t         ctrl_w;
  logic [CW-1:0] reload_w, cnt_w;
  logic [PW-1:0] psc_w;
  logic          start_w, expire_w, tick_w, evt_w;
  logic          pin_lvl, pin_rise;
  logic          run_w, autorl_w, tgl_w;

  assign wr_any    = bus_sel & bus_we;
  assign ctrl_wr   = wr_any & (bus_addr == OFF_CTRL);
  assign reload_wr = wr_any & (bus_addr == OFF_RELOAD);
  assign psc_wr    = wr_any & (bus_addr == OFF_PSC);

  ival_timer_regs #(.CW(CW), .PW(PW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ctrl_wr   (ctrl_wr),
    .reload_wr (reload_wr),
    .psc_wr    (psc_wr),
    .wdata     (bus_wdata),
    .expire    (expire_w),
    .ctrl_o    (ctrl_w),
    .irq_o     (irq),
    .reload_o  (reload_w),
    .psc_o     (psc_w),
    .start_o   (start_w)
  );

  assign run_w    = ctrl_w.run;
  assign autorl_w = ctrl_w.autorl;
  assign tgl_w    = ctrl_w.tgl;

  ival_timer_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .pin_i  (ev_pin),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise)
  );

  ival_timer_prescale #(.PW(PW)) u_psc (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .restart (start_w),
    .active  (run_w & ~ctrl_w.ext),
    .div     (psc_w),
    .tick    (tick_w)
  );

  always_comb begin
    if (ctrl_w.ext) evt_w = pin_rise;
    else            evt_w = tick_w & (~ctrl_w.gate | pin_lvl);
  end

  ival_timer_count #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (start_w),
    .evt      (evt_w),
    .run      (run_w),
    .autorl   (autorl_w),
    .tgl      (tgl_w),
    .reload   (reload_w),
    .cnt_o    (cnt_w),
    .expire_o (expire_w),
    .out_o    (tmr_pin)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_CTRL:   bus_rdata[IRQ_BIT:0] = {irq, ctrl_w};
      OFF_RELOAD: bus_rdata = reload_w;
      OFF_PSC:    bus_rdata[PW-1:0] = psc_w;
      default:    bus_rdata = cnt_w;
    endcase
  end

endmodule

// File: rtl/ival_timer_chk.sv
module ival_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_wr,
  input logic          reload_wr,
  input logic [CW-1:0] wdata,
  input logic          run,
  input logic          autorl,
  input logic          tgl,
  input logic          evt,
  input logic [CW-1:0] reload,
  input logic [CW-1:0] cnt,
  input logic          out,
  input logic          irq
);

  a_r2_reload_write: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> (reload == $past(wdata)));

  a_r3_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[0] && !run) |=> (run && cnt == $past(reload)));

  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(ctrl_wr && wdata[5])) |=> irq);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && run && cnt == '0) |=> irq);

  a_r6_auto_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && run && cnt == '0 && autorl && !ctrl_wr) |=> (run && cnt == $past(reload)));

  a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && run && cnt == '0 && !autorl && !ctrl_wr) |=> (!run && cnt == '0));

  a_r8_pulse_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (out && !tgl && $past(tgl) == 1'b0) |-> irq);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !(ctrl_wr && wdata[0] && !run)) |=> $stable(cnt));

endmodule

bind ival_timer ival_timer_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .ctrl_wr   (ctrl_wr),
  .reload_wr (reload_wr),
  .wdata     (bus_wdata),
  .run       (run_w),
  .autorl    (autorl_w),
  .tgl       (tgl_w),
  .evt       (evt_w),
  .reload    (reload_w),
  .cnt       (cnt_w),
  .out       (tmr_pin),
  .irq       (irq)
);

// File: tb/ival_timer_tb.sv
module ival_timer_tb;
  localparam int CW = 8;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [1:0]    bus_addr = 2'd0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          ev_pin = 1'b0;
  logic          tmr_pin;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ival_timer #(.CW(CW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_pin(ev_pin), .tmr_pin(tmr_pin), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d[CW-1:0];
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 output pin reset", int'(tmr_pin), 0);
    chk("R1 irq reset", int'(irq), 0);
  endtask

  task automatic t_regmap();
    int v;
    wr(2'd1, 8'h5A); rd(2'd1, v); chk("R2 reload readback", v, 8'h5A);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R2 prescaler low bits", v, 8'h0F);
    wr(2'd0, 8'h0C); rd(2'd0, v); chk("R2 control readback", v, 8'h0C);
    wr(2'd0, 0);
    wr(2'd3, 8'h77); rd(2'd3, v); chk("R2 count is read-only", v, 0);
  endtask

  task automatic t_oneshot(input int r, input int p);
    int v, n;
    wr(2'd1, r); wr(2'd2, p); wr(2'd0, 8'h01);
    rd(2'd3, v); chk("R3 start loads reload", v, r);
    wait_irq(n); chk("R4 clocks to expiry", n, (r + 1) * (p + 1));
    chk("R8 pulse high after expiry", int'(tmr_pin), 1);
    step(1); chk("R8 pulse one clock wide", int'(tmr_pin), 0);
    rd(2'd0, v); chk("R7 run cleared, flag set", v, 8'h20);
    rd(2'd3, v); chk("R7 count parked at zero", v, 0);
    step(8); chk("R5 flag sticky", int'(irq), 1);
    rd(2'd3, v); chk("R7 count stays zero", v, 0);
    wr(2'd0, 8'h20); chk("R5 write one clears flag", int'(irq), 0);
  endtask

  task automatic t_auto_toggle();
    int v, n;
    wr(2'd1, 2); wr(2'd2, 1); wr(2'd0, 8'h07);
    wait_irq(n); chk("R6 first period", n, 6);
    chk("R9 toggle high after first expiry", int'(tmr_pin), 1);
    rd(2'd3, v); chk("R6 reloaded count", v, 2);
    step(6);
    chk("R9 toggle low after second expiry", int'(tmr_pin), 0);
    rd(2'd0, v); chk("R6 run stays set", v, 8'h27);
    step(2); rd(2'd3, v); chk("R6 continues counting", v, 1);
    wr(2'd0, 8'h20);
    chk("R5 flag cleared after stop", int'(irq), 0);
    chk("R9 level held after stop", int'(tmr_pin), 0);
  endtask

  task automatic t_set_wins();
    wr(2'd1, 0); wr(2'd2, 0); wr(2'd0, 8'h03);
    step(2);
    chk("R8 pulse held on back-to-back expiry", int'(tmr_pin), 1);
    wr(2'd0, 8'h23);
    chk("R5 set wins over clear", int'(irq), 1);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h20);
    chk("R5 clear when idle", int'(irq), 0);
  endtask

  task automatic t_gate();
    int v, n;
    ev_pin = 1'b0;
    wr(2'd1, 3); wr(2'd2, 0); wr(2'd0, 8'h09);
    step(10); rd(2'd3, v); chk("R10 gate low holds count", v, 3);
    chk("R10 no expiry while gated", int'(irq), 0);
    ev_pin = 1'b1;
    wait_irq(n); chk("R10 clocks to expiry after gate opens", n, 6);
    ev_pin = 1'b0;
    wr(2'd0, 8'h20);
  endtask

  task automatic t_ext();
    int v;
    ev_pin = 1'b0;
    wr(2'd1, 2); wr(2'd2, 5); wr(2'd0, 8'h11);
    ev_pin = 1'b1; step(12);
    rd(2'd3, v); chk("R11 long high level is one edge", v, 1);
    ev_pin = 1'b0; step(3);
    ev_pin = 1'b1; step(3); ev_pin = 1'b0; step(3);
    rd(2'd3, v); chk("R11 second edge", v, 0);
    chk("R11 no expiry yet", int'(irq), 0);
    ev_pin = 1'b1; step(3); ev_pin = 1'b0; step(3);
    chk("R11 third edge expires", int'(irq), 1);
    rd(2'd0, v); chk("R11 one-shot stop in event mode", v, 8'h30);
    wr(2'd0, 8'h20);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(5);
    t_reset();
    t_regmap();
    t_oneshot(4, 0);
    t_oneshot(3, 2);
    t_oneshot(2, 15);
    t_auto_toggle();
    t_set_wins();
    t_gate();
    t_ext();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule